// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one raw operation on an 8-bit NAND flash bus at a time. Software first fills a few registers: two opcodes, up to eight address bytes, a byte count and a strobe timing word. It then writes an operation word. Each phase of the operation has its own enable bit in that word, so the same engine can issue reset, identify, status, erase, program-style and plain read sequences. Enabled phases always run in one fixed order: first opcode, address bytes, outgoing data, incoming data, second opcode, then a wait for the flash to report ready. Phases that are not enabled are skipped.

The block drives the command-latch and address-latch strobes, the active-low write and read strobes, one active-low enable per flash device, and the data bus with its output enable. It samples the ready/busy line. Bytes read from the flash land in a small on-chip buffer. Software reads that buffer through a separate index port. The same buffer, filled by software, supplies the outgoing data bytes. A single status bit reports that the engine is idle and the selected flash is ready.

Top module: `nand_seq`

## Requirements
- R1: After reset the engine is idle. The write and read strobes are high, the command and address latch strobes are low, every device enable is high and the bus is not driven. The timing word resets to a write-strobe low count of 5, a read-strobe low count of 7 and a shared high count of 3.
- R2: Register select 0 holds the first opcode in bits [7:0] and the second opcode in bits [15:8]. Each opcode goes out on the bus during its own write-strobe pulse, with the command latch high for the whole phase.
- R3: In the operation word (select 5), bit 6 enables the first opcode, bit 5 the address, bit 4 outgoing data, bit 1 incoming data, bit 3 the second opcode and bit 2 the ready wait. The phases run in exactly that order, and disabled phases are skipped.
- R4: Bits [8:7] of the operation word pick one device. Only that device's active-low enable is low while an operation runs. All enables are high when the engine is idle.
- R5: Bits [11:9] of the operation word give the number of address bytes. The bytes are taken least significant first from the low address word (select 1) and then the high word (select 2), with the address latch high. A count of zero skips the address phase.
- R6: Timing word (select 4) fields: bits [3:0] set the write-strobe low count, bits [7:4] the read-strobe low count and bits [11:8] the high count. Each pulse stays low for its low count + 1 clocks. Consecutive pulses of one operation are separated by high count + 1 clocks.
- R7: The byte count (select 3) sets how many bytes the incoming data phase collects. Each byte is sampled while the read strobe is low, on its last low clock, and stored at buffer index 0, 1, 2 and so on. A count of zero skips the phase.
- R8: The outgoing data phase sends the same number of bytes from buffer index 0 upward, one per write-strobe pulse, with both latch strobes low. Software writes the buffer through select 6: the byte in bits [7:0] and the index from bit 8 up.
- R9: The ready wait ignores the busy line for GAP_CYC clocks after the last strobe pulse ends. It then waits until the line is high. With the line already high, the status bit rises high count + GAP_CYC + 2 clocks after the last write strobe rises.
- R10: The status bit is 1 exactly when the engine is idle and the ready/busy line is high. It reads 0 in the cycle after an accepted operation write.
- R11: An operation word written while the engine is busy is ignored. The running operation issues no extra pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..6) |
| reg_wdata | input | 32 | Register write data |
| buf_rd_idx | input | AW | Buffer read index |
| buf_rd_data | output | 8 | Buffer byte at buf_rd_idx |
| seq_ready | output | 1 | Idle and flash ready |
| nf_cle | output | 1 | Command latch strobe |
| nf_ale | output | 1 | Address latch strobe |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_ce_n | output | NUM_CE | Device enables, active low |
| nf_dq_o | output | 8 | Bus data out |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_i | input | 8 | Bus data in |
| nf_rb | input | 1 | Ready/busy line, high = ready |

## Verification
Identify-style sequences are swept over all four device selects and several byte counts. This shows whether the device enable decode and the read capture index are correct. Erase-style sequences are swept over one to seven address bytes against a pair of address words whose every byte differs. This shows the byte order and the cycle-count boundary. A grid of write-low, read-low and high counts, including 0 and 15, shows whether each strobe uses its own low field. A full write-and-read sequence checks that the phase order is fixed. Zero counts, a held-low busy line and a second operation word written mid-run check the skip, wait and ignore behaviour.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD1,
      ST_ADDR,
      ST_WDAT,
      ST_RDAT,
      ST_CMD2,
      ST_WGAP,
      ST_WPOLL
   } seq_st_e;

   // operation word bit positions (decoded by the sequencer)
   localparam int OPB_RD    = 1;
   localparam int OPB_WAIT  = 2;
   localparam int OPB_CMD2  = 3;
   localparam int OPB_WR    = 4;
   localparam int OPB_ADDR  = 5;
   localparam int OPB_CMD1  = 6;
   localparam int OPF_CS    = 7;
   localparam int OPF_NAD   = 9;
   localparam int OP_W      = 12;

   // register selects
   localparam logic [2:0] RS_CMD = 3'd0;
   localparam logic [2:0] RS_ADL = 3'd1;
   localparam logic [2:0] RS_ADH = 3'd2;
   localparam logic [2:0] RS_CNT = 3'd3;
   localparam logic [2:0] RS_TIM = 3'd4;
   localparam logic [2:0] RS_OP  = 3'd5;
   localparam logic [2:0] RS_BUF = 3'd6;

   localparam logic [11:0] TIM_RESET = 12'h375;

   function automatic logic is_strobe(input seq_st_e s);
      return (s == ST_CMD1) || (s == ST_ADDR) || (s == ST_WDAT) ||
             (s == ST_RDAT) || (s == ST_CMD2);
   endfunction

endpackage

// File: rtl/nand_seq_pulse.sv
module nand_seq_pulse #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [CW-1:0] lo_cnt,
   input  logic [CW-1:0] hi_cnt,
   output logic          strobe_low,
   output logic          sample,
   output logic          done,
   output logic          busy
);

   if (CW < 1) begin : g_bad_cw
      $error("nand_seq_pulse: CW must be at least 1");
   end

   typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

   ph_e           ph;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (go) begin
               ph  <= PH_LOW;
               cnt <= lo_cnt;
            end
            PH_LOW: if (cnt == '0) begin
               ph  <= PH_HIGH;
               cnt <= hi_cnt;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_HIGH: if (cnt == '0) begin
               if (go) begin
                  ph  <= PH_LOW;
                  cnt <= lo_cnt;
               end else begin
                  ph <= PH_IDLE;
               end
            end else begin
               cnt <= cnt - 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign strobe_low = (ph == PH_LOW);
   assign sample     = (ph == PH_LOW) && (cnt == '0);
   assign done       = (ph == PH_HIGH) && (cnt == '0);
   assign busy       = (ph != PH_IDLE);

   // R6: low time is not cut short
   a_r6_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_LOW && cnt != '0) |=> (ph == PH_LOW));
   // R6: high time is not cut short
   a_r6_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_HIGH && cnt != '0) |=> (ph == PH_HIGH));
   // R6: a launch only arrives when the timer is free
   a_r6_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (!busy || done));

endmodule

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          sw_we,
   input  logic [AW-1:0] sw_idx,
   input  logic [7:0]    sw_byte,
   input  logic          cap_we,
   input  logic [AW-1:0] cap_idx,
   input  logic [7:0]    cap_byte,
   input  logic [AW-1:0] rd_idx_a,
   output logic [7:0]    rd_a,
   input  logic [AW-1:0] rd_idx_b,
   output logic [7:0]    rd_b
);

   logic [7:0] mem [DEPTH];

   // flash capture has priority over a software write in the same cycle
   always_ff @(posedge clk) begin
      if (cap_we) begin
         mem[cap_idx] <= cap_byte;
      end else if (sw_we) begin
         mem[sw_idx] <= sw_byte;
      end
   end

   assign rd_a = mem[rd_idx_a];
   assign rd_b = mem[rd_idx_b];

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
   import nand_seq_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int GAP_CYC = 4,
   localparam int GW     = $clog2(GAP_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_wr,
   input  logic [OP_W-1:0]  op_word,
   input  logic [CNT_W-1:0] dcnt,
   input  logic             rb,
   input  logic             stb_done,
   input  logic             stb_busy,
   output seq_st_e          st,
   output logic             go,
   output logic             go_rd,
   output logic [2:0]       acnt,
   output logic [CNT_W-1:0] didx,
   output logic [OP_W-1:0]  op_q
);

   if (GAP_CYC < 1) begin : g_bad_gap
      $error("nand_seq_fsm: GAP_CYC must be at least 1");
   end

   seq_st_e         nxt;
   logic [OP_W-1:0] op_sel;
   logic [5:0]      en;
   logic [2:0]      nad;
   logic [GW-1:0]   gcnt;

   assign op_sel = (st == ST_IDLE) ? op_word : op_q;
   assign nad    = op_sel[OPF_NAD +: 3];

   // phase enables in run order; zero counts skip their phase
   assign en[0] = op_sel[OPB_CMD1];
   assign en[1] = op_sel[OPB_ADDR] && (nad != 3'd0);
   assign en[2] = op_sel[OPB_WR]   && (dcnt != '0);
   assign en[3] = op_sel[OPB_RD]   && (dcnt != '0);
   assign en[4] = op_sel[OPB_CMD2];
   assign en[5] = op_sel[OPB_WAIT];

   function automatic seq_st_e slot(input int i);
      case (i)
         0:       return ST_CMD1;
         1:       return ST_ADDR;
         2:       return ST_WDAT;
         3:       return ST_RDAT;
         4:       return ST_CMD2;
         default: return ST_WGAP;
      endcase
   endfunction

   function automatic seq_st_e pick(input int from, input logic [5:0] e);
      seq_st_e r;
      r = ST_IDLE;
      for (int i = 5; i >= 0; i--) begin
         if (i >= from && e[i]) r = slot(i);
      end
      return r;
   endfunction

   always_comb begin
      nxt = st;
      case (st)
         ST_IDLE:  if (op_wr) nxt = pick(0, en);
         ST_CMD1:  if (stb_done) nxt = pick(1, en);
         ST_ADDR:  if (stb_done && acnt == nad - 3'd1) nxt = pick(2, en);
         ST_WDAT:  if (stb_done && didx == dcnt - CNT_W'(1)) nxt = pick(3, en);
         ST_RDAT:  if (stb_done && didx == dcnt - CNT_W'(1)) nxt = pick(4, en);
         ST_CMD2:  if (stb_done) nxt = pick(5, en);
         ST_WGAP:  if (gcnt == '0) nxt = ST_WPOLL;
         ST_WPOLL: if (rb) nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   assign go    = is_strobe(nxt) && (!stb_busy || stb_done);
   assign go_rd = go && (nxt == ST_RDAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         op_q <= '0;
         acnt <= '0;
         didx <= '0;
         gcnt <= '0;
      end else begin
         st <= nxt;
         if (st == ST_IDLE && op_wr) op_q <= op_word;
         if (st != nxt) acnt <= '0;
         else if (st == ST_ADDR && stb_done) acnt <= acnt + 3'd1;
         if (st != nxt) didx <= '0;
         else if ((st == ST_WDAT || st == ST_RDAT) && stb_done) didx <= didx + CNT_W'(1);
         if (nxt == ST_WGAP && st != ST_WGAP) gcnt <= GW'(GAP_CYC - 1);
         else if (st == ST_WGAP && gcnt != '0) gcnt <= gcnt - 1'b1;
      end
   end

   // R11: a write while busy leaves the latched operation untouched
   a_r11_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && op_wr) |=> $stable(op_q));
   // R9: the blind window never ends the operation directly
   a_r9_gap_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WGAP) |=> (st != ST_IDLE));
   // R9: polling holds while the flash is busy
   a_r9_poll_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WPOLL && !rb) |=> (st == ST_WPOLL));

endmodule

// File: rtl/nand_seq.sv
module nand_seq
   import nand_seq_pkg::*;
#(
   parameter int BUF_DEPTH = 16,
   parameter int CNT_W     = 8,
   parameter int NUM_CE    = 4,
   parameter int GAP_CYC   = 4,
   localparam int AW       = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   input  logic [AW-1:0]     buf_rd_idx,
   output logic [7:0]        buf_rd_data,
   output logic              seq_ready,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   output logic [NUM_CE-1:0] nf_ce_n,
   output logic [7:0]        nf_dq_o,
   output logic              nf_dq_oe,
   input  logic [7:0]        nf_dq_i,
   input  logic              nf_rb
);

   if (BUF_DEPTH < 2 || (1 << AW) != BUF_DEPTH) begin : g_bad_depth
      $error("nand_seq: BUF_DEPTH must be a power of two of at least 2");
   end
   if (NUM_CE < 1 || NUM_CE > 4) begin : g_bad_ce
      $error("nand_seq: NUM_CE must be 1..4");
   end
   if (CNT_W < AW || CNT_W > 24) begin : g_bad_cnt
      $error("nand_seq: CNT_W must cover the buffer index and fit the data word");
   end

   // ---------------- software registers ----------------
   logic [15:0]      cmd_q;
   logic [31:0]      adl_q, adh_q;
   logic [CNT_W-1:0] dcnt_q;
   logic [11:0]      tim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         adl_q  <= '0;
         adh_q  <= '0;
         dcnt_q <= '0;
         tim_q  <= TIM_RESET;
      end else if (reg_we) begin
         case (reg_sel)
            RS_CMD:  cmd_q  <= reg_wdata[15:0];
            RS_ADL:  adl_q  <= reg_wdata;
            RS_ADH:  adh_q  <= reg_wdata;
            RS_CNT:  dcnt_q <= reg_wdata[CNT_W-1:0];
            RS_TIM:  tim_q  <= reg_wdata[11:0];
            default: ;
         endcase
      end
   end

   // ---------------- sequencer and pulse timer ----------------
   seq_st_e          st;
   logic             go, go_rd, stb_low, stb_sample, stb_done, stb_busy;
   logic [2:0]       acnt;
   logic [CNT_W-1:0] didx;
   logic [OP_W-1:0]  op_q;
   logic             op_wr;
   logic [3:0]       lo_sel;

   assign op_wr  = reg_we && (reg_sel == RS_OP);
   assign lo_sel = go_rd ? tim_q[7:4] : tim_q[3:0];

   nand_seq_fsm #(.CNT_W(CNT_W), .GAP_CYC(GAP_CYC)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_wr    (op_wr),
      .op_word  (reg_wdata[OP_W-1:0]),
      .dcnt     (dcnt_q),
      .rb       (nf_rb),
      .stb_done (stb_done),
      .stb_busy (stb_busy),
      .st       (st),
      .go       (go),
      .go_rd    (go_rd),
      .acnt     (acnt),
      .didx     (didx),
      .op_q     (op_q)
   );

   nand_seq_pulse #(.CW(4)) u_pulse (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .lo_cnt     (lo_sel),
      .hi_cnt     (tim_q[11:8]),
      .strobe_low (stb_low),
      .sample     (stb_sample),
      .done       (stb_done),
      .busy       (stb_busy)
   );

   // ---------------- byte buffer ----------------
   logic [7:0] tx_byte;

   nand_seq_buf #(.DEPTH(BUF_DEPTH)) u_buf (
      .clk      (clk),
      .sw_we    (reg_we && reg_sel == RS_BUF),
      .sw_idx   (reg_wdata[8 +: AW]),
      .sw_byte  (reg_wdata[7:0]),
      .cap_we   (st == ST_RDAT && stb_sample),
      .cap_idx  (didx[AW-1:0]),
      .cap_byte (nf_dq_i),
      .rd_idx_a (buf_rd_idx),
      .rd_a     (buf_rd_data),
      .rd_idx_b (didx[AW-1:0]),
      .rd_b     (tx_byte)
   );

   wire didx_unused = ^didx;
   wire op_unused   = ^op_q[6:0];

   // ---------------- flash pins ----------------
   logic [63:0] addr_all;
   logic [1:0]  cs;
   logic        active;

   assign addr_all = {adh_q, adl_q};
   assign cs       = op_q[OPF_CS +: 2];
   assign active   = (st != ST_IDLE);

   for (genvar g = 0; g < NUM_CE; g++) begin : g_ce
      assign nf_ce_n[g] = !(active && int'(cs) == g);
   end

   always_comb begin
      case (st)
         ST_CMD1: nf_dq_o = cmd_q[7:0];
         ST_CMD2: nf_dq_o = cmd_q[15:8];
         ST_ADDR: nf_dq_o = addr_all[{acnt, 3'b000} +: 8];
         ST_WDAT: nf_dq_o = tx_byte;
         default: nf_dq_o = 8'h00;
      endcase
   end

   assign nf_dq_oe  = (st == ST_CMD1) || (st == ST_CMD2) ||
                      (st == ST_ADDR) || (st == ST_WDAT);
   assign nf_cle    = (st == ST_CMD1) || (st == ST_CMD2);
   assign nf_ale    = (st == ST_ADDR);
   assign nf_we_n   = !(stb_low && st != ST_RDAT);
   assign nf_re_n   = !(stb_low && st == ST_RDAT);
   assign seq_ready = !active && nf_rb;

   // R2: latch strobes never overlap
   a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_cle && nf_ale));
   // R6: write and read strobes never low together
   a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_we_n && !nf_re_n));
   // R4: at most one device enabled, none while idle
   a_r4_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~nf_ce_n) <= 1);
   a_r4_idle_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
      seq_ready |-> (&nf_ce_n));
   // R10: an accepted start with the first opcode enabled drops ready
   a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_ready && op_wr && reg_wdata[OPB_CMD1]) |=> !seq_ready);
   // R7: the bus is never driven while reading
   a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_re_n |-> !nf_dq_oe);

endmodule

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
   localparam int GAP = 4;
   localparam int DEPTH = 16;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          reg_we = 1'b0;
   logic [2:0]    reg_sel = '0;
   logic [31:0]   reg_wdata = '0;
   logic [AW-1:0] buf_rd_idx = '0;
   logic [7:0]    buf_rd_data;
   logic          seq_ready, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
   logic [3:0]    nf_ce_n;
   logic [7:0]    nf_dq_o, nf_dq_i;
   logic          nf_rb = 1'b1;

   nand_seq #(.BUF_DEPTH(DEPTH), .GAP_CYC(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
      .seq_ready(seq_ready), .nf_cle(nf_cle), .nf_ale(nf_ale),
      .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_ce_n(nf_ce_n),
      .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
   );

   int tests = 0, fails = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // ---------------- pin monitor ----------------
   int ev_k[256], ev_b[256], ev_w[256], ev_g[256], ev_ce[256];
   int rd_w[256], rd_g[256];
   int n_ev = 0, n_rd = 0, last_rise = 0;
   int wlow = 0, whigh = 0, fgap = 0, lk = 0, ldq = 0, lce = 0;
   int rlow = 0, rhigh = 0, rgap = 0;
   logic pwe = 1'b1, pre = 1'b1;

   assign nf_dq_i = 8'(8'h3C + 8'h15 * n_rd);

   always @(negedge clk) begin
      if (!nf_we_n) begin
         if (pwe) begin fgap = whigh; wlow = 0; end
         wlow++;
         ldq = nf_dq_o;
         lk  = nf_cle ? 1 : (nf_ale ? 2 : 3);
         lce = nf_ce_n;
      end else begin
         if (!pwe && n_ev < 256) begin
            ev_k[n_ev] = lk; ev_b[n_ev] = ldq; ev_w[n_ev] = wlow;
            ev_g[n_ev] = fgap; ev_ce[n_ev] = lce;
            n_ev++;
            last_rise = cyc;
            whigh = 0;
         end
         whigh++;
      end
      pwe = nf_we_n;
      if (!nf_re_n) begin
         if (pre) begin rgap = rhigh; rlow = 0; end
         rlow++;
      end else begin
         if (!pre && n_rd < 256) begin
            rd_w[n_rd] = rlow; rd_g[n_rd] = rgap;
            n_rd++;
            rhigh = 0;
         end
         rhigh++;
      end
      pre = nf_re_n;
   end

   // ---------------- helpers ----------------
   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic logic [31:0] mk_op(input bit c1, input bit ad, input bit wr,
         input bit rd, input bit c2, input bit wt, input int cs, input int nad);
      logic [31:0] v;
      v = '0;
      v[6] = c1; v[5] = ad; v[4] = wr; v[1] = rd; v[3] = c2; v[2] = wt;
      v[8:7] = 2'(cs); v[11:9] = 3'(nad);
      return v;
   endfunction

   task automatic wait_ready(output int rcyc);
      int k;
      k = 0;
      while (!seq_ready && k < 5000) begin
         @(negedge clk);
         k++;
      end
      rcyc = cyc;
   endtask

   task automatic run_op(input logic [31:0] op, output int rcyc);
      wreg(3'd5, op);
      check("R10 ready drops after start", seq_ready, 0);
      wait_ready(rcyc);
   endtask

   function automatic int rdexp(input int k);
      return int'(8'(8'h3C + 8'h15 * k));
   endfunction

   // ---------------- stimulus ----------------
   initial begin
      int rc, b0, r0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 ready", seq_ready, 1);
      check("R1 we_n", nf_we_n, 1);
      check("R1 re_n", nf_re_n, 1);
      check("R1 cle", nf_cle, 0);
      check("R1 ale", nf_ale, 0);
      check("R1 ce_n", nf_ce_n, 4'hF);
      check("R1 dq_oe", nf_dq_oe, 0);
      nf_rb = 1'b0;
      @(negedge clk);
      check("R10 idle but busy line low", seq_ready, 0);
      nf_rb = 1'b1;

      // reset-style sequence: first opcode then wait, default timing (R1, R6, R9)
      wreg(3'd0, 32'h0000_00FF);
      b0 = n_ev;
      run_op(mk_op(1, 0, 0, 0, 0, 1, 0, 0), rc);
      check("R3 reset seq one pulse", n_ev - b0, 1);
      check("R2 reset opcode", ev_b[b0], 8'hFF);
      check("R2 cle during opcode", ev_k[b0], 1);
      check("R1 default write low width", ev_w[b0], 6);
      check("R4 ce0 only", ev_ce[b0], 4'hE);
      check("R9 ready delay after last strobe", rc - last_rise, 3 + GAP + 2);

      // identify-style over all device selects (R4, R5, R7, R1 read timing)
      wreg(3'd0, 32'h0000_0090);
      for (int cs = 0; cs < 4; cs++) begin
         wreg(3'd1, 32'h0000_00A5 + 32'(cs));
         wreg(3'd3, 32'(4 + cs));
         b0 = n_ev; r0 = n_rd;
         run_op(mk_op(1, 1, 0, 1, 0, 0, cs, 1), rc);
         check("R3 id pulses", n_ev - b0, 2);
         check("R2 id opcode", ev_b[b0], 8'h90);
         check("R5 id addr kind", ev_k[b0 + 1], 2);
         check("R5 id addr byte", ev_b[b0 + 1], 8'hA5 + cs);
         check("R4 ce select", ev_ce[b0 + 1], 4'hF & ~(1 << cs));
         check("R7 read count", n_rd - r0, 4 + cs);
         for (int k = 0; k < 4 + cs; k++) begin
            check("R1 default read low width", rd_w[r0 + k], 8);
            if (k > 0) check("R1 default high width", rd_g[r0 + k], 4);
            buf_rd_idx = AW'(k);
            #1;
            check("R7 captured byte", buf_rd_data, rdexp(r0 + k));
         end
      end

      // erase-style over address counts 1..7 (R2, R3, R5, R9)
      wreg(3'd0, 32'h0000_D060);
      wreg(3'd1, 32'h4433_2211);
      wreg(3'd2, 32'h8877_6655);
      for (int n = 1; n < 8; n++) begin
         b0 = n_ev;
         if (n == 3) begin
            nf_rb = 1'b0;
            wreg(3'd5, mk_op(1, 1, 0, 0, 1, 1, 1, n));
            repeat (60) @(negedge clk);
            check("R9 held while busy line low", seq_ready, 0);
            nf_rb = 1'b1;
            @(negedge clk);
            check("R9 ready once line high", seq_ready, 1);
         end else begin
            run_op(mk_op(1, 1, 0, 0, 1, 1, 1, n), rc);
         end
         check("R3 erase pulse count", n_ev - b0, n + 2);
         check("R2 first opcode", ev_b[b0], 8'h60);
         check("R2 second opcode", ev_b[b0 + n + 1], 8'hD0);
         check("R2 second opcode cle", ev_k[b0 + n + 1], 1);
         for (int k = 0; k < n; k++) begin
            check("R5 addr byte order", ev_b[b0 + 1 + k], int'(8'(8'h11 * (k + 1))));
            check("R5 ale", ev_k[b0 + 1 + k], 2);
         end
      end

      // timing grid with outgoing and incoming data (R6, R8, R7)
      wreg(3'd0, 32'h0000_0080);
      wreg(3'd3, 32'd3);
      for (int li = 0; li < 3; li++) begin
         for (int hi_i = 0; hi_i < 3; hi_i++) begin
            int lo, hi, rlo, base;
            lo  = (li == 0) ? 0 : (li == 1) ? 3 : 15;
            hi  = (hi_i == 0) ? 0 : (hi_i == 1) ? 2 : 9;
            rlo = (lo + 5) % 16;
            base = 8'h40 + 3 * (li * 3 + hi_i);
            wreg(3'd4, 32'((hi << 8) | (rlo << 4) | lo));
            for (int k = 0; k < 3; k++) wreg(3'd6, 32'((k << 8) | (base + k)));
            wreg(3'd3, 32'd3);
            b0 = n_ev;
            run_op(mk_op(1, 0, 1, 0, 0, 0, 2, 0), rc);
            check("R8 write pulse count", n_ev - b0, 4);
            check("R6 opcode low width", ev_w[b0], lo + 1);
            for (int k = 0; k < 3; k++) begin
               check("R8 data byte", ev_b[b0 + 1 + k], base + k);
               check("R8 data kind", ev_k[b0 + 1 + k], 3);
               check("R6 write low width", ev_w[b0 + 1 + k], lo + 1);
               check("R6 high width", ev_g[b0 + 1 + k], hi + 1);
            end
            wreg(3'd3, 32'd2);
            r0 = n_rd;
            run_op(mk_op(0, 0, 0, 1, 0, 0, 2, 0), rc);
            check("R7 read pulse count", n_rd - r0, 2);
            check("R6 read low width", rd_w[r0], rlo + 1);
            check("R6 read low width 2", rd_w[r0 + 1], rlo + 1);
            check("R6 read high width", rd_g[r0 + 1], hi + 1);
         end
      end

      // busy write ignored (R11)
      wreg(3'd4, 32'h0000_0FFF);
      wreg(3'd0, 32'h0000_2211);
      b0 = n_ev;
      wreg(3'd5, mk_op(1, 0, 0, 0, 0, 0, 3, 0));
      check("R10 ready drops", seq_ready, 0);
      wreg(3'd5, mk_op(1, 0, 0, 0, 1, 0, 0, 0));
      wait_ready(rc);
      repeat (60) @(negedge clk);
      check("R11 no extra pulses", n_ev - b0, 1);
      check("R11 original device kept", ev_ce[b0], 4'h7);
      check("R11 idle afterwards", seq_ready, 1);

      // zero counts skip their phases (R5, R7)
      wreg(3'd4, 32'h0000_0375);
      wreg(3'd3, 32'd0);
      b0 = n_ev; r0 = n_rd;
      run_op(mk_op(1, 1, 0, 1, 0, 0, 0, 0), rc);
      check("R5 zero address count skipped", n_ev - b0, 1);
      check("R7 zero data count skipped", n_rd - r0, 0);

      // full order with every strobe phase (R3)
      wreg(3'd0, 32'h0000_1085);
      wreg(3'd6, 32'h0000_00C1);
      wreg(3'd6, 32'h0000_01C2);
      wreg(3'd3, 32'd2);
      b0 = n_ev; r0 = n_rd;
      run_op(mk_op(1, 1, 1, 1, 1, 0, 1, 2), rc);
      check("R3 order pulse count", n_ev - b0, 6);
      check("R3 order reads", n_rd - r0, 2);
      check("R3 order 0", ev_b[b0], 8'h85);
      check("R3 order 1", ev_b[b0 + 1], 8'h11);
      check("R3 order 2", ev_b[b0 + 2], 8'h22);
      check("R3 order 3", ev_b[b0 + 3], 8'hC1);
      check("R3 order 4", ev_b[b0 + 4], 8'hC2);
      check("R3 order 5", ev_b[b0 + 5], 8'h10);
      check("R3 order kinds", ev_k[b0 + 3] * 10 + ev_k[b0 + 5], 31);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule